// File: doc/BRIEF.md
# Dual Channel Programmable Frequency Dividers

This block holds the counting section of a two-channel frequency synthesizer. A single reference counter divides the oscillator by a programmed ratio and drives the comparison pulse of both channels. The second channel can instead take every other reference terminal, which halves its comparison rate. Each channel also has its own main counter. It divides that channel's RF input events by a programmed ratio and produces the feedback pulse that a phase comparator downstream lines up against the comparison pulse.

All logic runs on one system clock. The oscillator and each RF input arrive as one-cycle tick enables. Every output is a registered pulse lasting one cycle. A ratio takes effect only when its counter reaches terminal, so no output period is ever cut short. A ratio below its legal minimum counts as that minimum. Each channel has a run control. Driving it low parks the channel. When it rises again, the channel stays armed until the next reference terminal, and at that point its main counter and its reference phase both start from full count. The first comparison and feedback edges after a wake-up are therefore aligned, which suits fast intermittent operation. The reference counter is held loaded while both channels are parked.

Top module: `dual_divider`

## Requirements
- R1: With both channels live, `cmp[0]` pulses once every R events on `ref_tick`, where R is `ref_div`.
- R2: With `half_sel` = 0, `cmp[1]` pulses in the same cycles as `cmp[0]`. With `half_sel` = 1, `cmp[1]` pulses on every second `cmp[0]` pulse, so its period is 2R.
- R3: Channel n's `fb[n]` pulses once every N events on `rf_tick[n]`, where N is `main_div_a` for n = 0 and `main_div_b` for n = 1. Ticks that are absent add cycles to the period but do not count.
- R4: When `ref_div` is below REF_MIN, R is REF_MIN. When a main ratio is below MAIN_MIN, N is MAIN_MIN. A value equal to the minimum is used unchanged.
- R5: A ratio changed during a period does not affect that period. It takes effect from the next terminal count.
- R6: While `run[n]` is 0, channel n produces no `cmp[n]` or `fb[n]` pulse. The other channel continues undisturbed.
- R7: After `run[n]` rises, channel n becomes live at the next reference terminal. Its first `cmp[n]` comes R reference ticks later and its first `fb[n]` comes N RF ticks later, both counted from that terminal. If both channels were parked, the reference counter restarts from full count, so with every tick present the first `cmp[0]` appears 2R cycles after the wake-up edge and the first `fb[0]` appears R+N cycles after it.
- R8: During reset, `cmp` and `fb` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle enable per oscillator event |
| rf_tick | input | NCH | One-cycle enable per RF input event, one per channel |
| run | input | NCH | Per-channel run control: 1 = operate, 0 = parked |
| half_sel | input | 1 | 1 = channel 1 comparison rate is half the reference rate |
| ref_div | input | REF_W | Reference ratio |
| main_div_a | input | MAIN_W | Main ratio for channel 0 |
| main_div_b | input | MAIN_W | Main ratio for channel 1 |
| cmp | output | NCH | Comparison pulse per channel |
| fb | output | NCH | Feedback pulse per channel |

## Verification
The bench builds the block with REF_W = 6, REF_MIN = 3, MAIN_W = 8 and MAIN_MIN = 5. Both counters therefore have short periods, and their full-scale ratios (63 and 255) fit in a short run. With these small widths the bench can test ratios below, at and at the top of the legal range, together with the halved second-channel rate. It can also measure wake-up alignment to the exact cycle and follow a ratio change across two successive periods.

// File: rtl/dd_pkg.sv
package dd_pkg;
  // number of synthesizer channels served by one reference counter
  localparam int unsigned NCH = 2;
endpackage

// File: rtl/dd_counter.sv
module dd_counter #(
  parameter int unsigned W   = 12,
  parameter int unsigned MIN = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic [W-1:0] ratio,
  output logic         term
);
  localparam logic [W-1:0] MIN_V = W'(MIN);
  localparam logic [W-1:0] ONE   = W'(1);

  logic [W-1:0] cnt;
  logic [W-1:0] eff;

  // ratios below the legal floor count as the floor
  assign eff  = (ratio < MIN_V) ? MIN_V : ratio;
  assign term = run && tick && (cnt == '0);

  // down-counter: the ratio is sampled only when parked or at terminal
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= eff - ONE;
    end else if (tick) begin
      cnt <= (cnt == '0) ? eff - ONE : cnt - ONE;
    end
  end
endmodule

// File: rtl/dd_channel.sv
module dd_channel #(
  parameter int unsigned MAIN_W   = 17,
  parameter int unsigned MAIN_MIN = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ref_term,
  input  logic              half,
  input  logic              rf_tick,
  input  logic [MAIN_W-1:0] ratio,
  output logic              cmp,
  output logic              fb,
  output logic              live
);
  logic live_q;
  logic tog_q;
  logic main_term;

  dd_counter #(.W(MAIN_W), .MIN(MAIN_MIN)) u_main (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (rf_tick),
    .run   (live_q),
    .ratio (ratio),
    .term  (main_term)
  );

  // armed on run, goes live on the shared reference terminal so that the
  // main count and the reference phase start on the same edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      tog_q  <= 1'b0;
      cmp    <= 1'b0;
      fb     <= 1'b0;
    end else begin
      cmp <= ref_term && live_q && (!half || tog_q);
      fb  <= main_term;
      if (!run) begin
        live_q <= 1'b0;
        tog_q  <= 1'b0;
      end else begin
        if (ref_term) live_q <= 1'b1;
        if (ref_term && live_q) tog_q <= ~tog_q;
      end
    end
  end

  assign live = live_q;
endmodule

// File: rtl/dual_divider.sv
module dual_divider
  import dd_pkg::*;
#(
  parameter int unsigned REF_W    = 12,
  parameter int unsigned REF_MIN  = 6,
  parameter int unsigned MAIN_W   = 17,
  parameter int unsigned MAIN_MIN = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [NCH-1:0]    rf_tick,
  input  logic [NCH-1:0]    run,
  input  logic              half_sel,
  input  logic [REF_W-1:0]  ref_div,
  input  logic [MAIN_W-1:0] main_div_a,
  input  logic [MAIN_W-1:0] main_div_b,
  output logic [NCH-1:0]    cmp,
  output logic [NCH-1:0]    fb
);
  logic              ref_term;
  logic [NCH-1:0]    half_v;
  logic [NCH-1:0]    live_w;
  logic [MAIN_W-1:0] mdiv [NCH];

  assign half_v[0] = 1'b0;
  assign half_v[1] = half_sel;
  assign mdiv[0]   = main_div_a;
  assign mdiv[1]   = main_div_b;

  // shared reference counter, parked only when every channel is parked
  dd_counter #(.W(REF_W), .MIN(REF_MIN)) u_ref (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (ref_tick),
    .run   (|run),
    .ratio (ref_div),
    .term  (ref_term)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dd_channel #(.MAIN_W(MAIN_W), .MAIN_MIN(MAIN_MIN)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run[i]),
      .ref_term (ref_term),
      .half     (half_v[i]),
      .rf_tick  (rf_tick[i]),
      .ratio    (mdiv[i]),
      .cmp      (cmp[i]),
      .fb       (fb[i]),
      .live     (live_w[i])
    );
  end
endmodule

// File: rtl/dual_divider_chk.sv
module dual_divider_chk
  import dd_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] run,
  input logic           half_sel,
  input logic [NCH-1:0] cmp,
  input logic [NCH-1:0] fb,
  input logic [NCH-1:0] live
);
  AST_REF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp[0] |=> !cmp[0]); // R1
  AST_HALF_OFF_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (&$past(live)) && !$past(half_sel) |-> cmp[0] == cmp[1]); // R2
  AST_HALF_ON_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (&$past(live)) && $past(half_sel) && cmp[1] |-> cmp[0]); // R2

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_FB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      fb[i] |=> !fb[i]); // R3
    AST_PARKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !run[i] && !$past(run[i]) && !$past(run[i], 2) |-> !cmp[i] && !fb[i]); // R6
    AST_NO_EARLY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(live[i]) |-> !cmp[i] && !fb[i]); // R7
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (cmp == '0 && fb == '0); // R8
    end
  end
endmodule

bind dual_divider dual_divider_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .half_sel (half_sel),
  .cmp      (cmp),
  .fb       (fb),
  .live     (live_w)
);

// File: tb/sim_dual_divider.sv
`timescale 1ns/1ps
module sim_dual_divider;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_tick;
  logic       rf0;
  logic       alt;
  logic [1:0] rf_tick;
  logic [1:0] run;
  logic       half_sel;
  logic [5:0] ref_div;
  logic [7:0] div_a;
  logic [7:0] div_b;
  logic [1:0] cmp;
  logic [1:0] fb;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  always @(negedge clk) rf0 <= alt ? ~rf0 : 1'b1;
  assign rf_tick = {1'b1, rf0};

  dual_divider #(.REF_W(6), .REF_MIN(3), .MAIN_W(8), .MAIN_MIN(5)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .rf_tick(rf_tick),
    .run(run), .half_sel(half_sel), .ref_div(ref_div),
    .main_div_a(div_a), .main_div_b(div_b), .cmp(cmp), .fb(fb)
  );

  // ref, div_a, div_b, half, exp R, exp N0, exp N1, exp cmp[1] period
  localparam int TBL [4][8] = '{
    '{10, 20, 30, 0, 10, 20, 30, 10},
    '{ 7,  9, 64, 1,  7,  9, 64, 14},
    '{ 2,  3,  5, 0,  3,  5,  5,  3},
    '{63,255,  6, 1, 63,255,  6,126}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit sig(input int sel);
    case (sel)
      0: return cmp[0];
      1: return cmp[1];
      2: return fb[0];
      default: return fb[1];
    endcase
  endfunction

  // cycles from the current negedge to the next pulse on sel
  task automatic since(input int sel, output int per);
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!sig(sel) && k < 2000);
    per = k;
  endtask

  task automatic gap(input int sel, output int per);
    int k = 0;
    while (!sig(sel) && k < 2000) begin
      @(negedge clk);
      k++;
    end
    since(sel, per);
  endtask

  task automatic setup(input int r, input int a, input int b, input int h);
    @(negedge clk);
    run = 2'b00; ref_div = 6'(r); div_a = 8'(a); div_b = 8'(b); half_sel = h[0];
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p, tc, tf, k, hits, co;
    rst_n = 1'b0; ref_tick = 1'b1; alt = 1'b0; run = 2'b11; half_sel = 1'b0;
    ref_div = 6'd10; div_a = 8'd20; div_b = 8'd30;
    repeat (6) @(negedge clk);
    chk("R8 outputs in reset", int'({cmp, fb}), 0);
    rst_n = 1'b1;

    // vector table: wake alignment, then each period
    for (int v = 0; v < 4; v++) begin
      setup(TBL[v][0], TBL[v][1], TBL[v][2], TBL[v][3]);
      run = 2'b11; tc = -1; tf = -1; k = 0;
      while ((tc < 0 || tf < 0) && k < 1000) begin
        @(negedge clk);
        k++;
        if (cmp[0] && tc < 0) tc = k;
        if (fb[0] && tf < 0) tf = k;
      end
      chk("R7 first cmp0 after wake", tc, 2 * TBL[v][4]);
      chk("R7 first fb0 after wake", tf, TBL[v][4] + TBL[v][5]);
      gap(0, p); chk("R1/R4 cmp0 period", p, TBL[v][4]);
      gap(1, p); chk("R2 cmp1 period", p, TBL[v][7]);
      gap(2, p); chk("R3/R4 fb0 period", p, TBL[v][5]);
      gap(3, p); chk("R3/R4 fb1 period", p, TBL[v][6]);
    end

    // R5: ratio changed mid-period applies from the next terminal
    setup(10, 20, 30, 0);
    run = 2'b11;
    gap(2, p);
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 3) div_a = 8'd12;
    end while (!fb[0] && k < 2000);
    chk("R5 period after change keeps old ratio", k, 20);
    since(2, p); chk("R5 following period uses new ratio", p, 12);

    // R3: absent RF ticks stretch the period
    div_a = 8'd20;
    gap(2, p);
    alt = 1'b1;
    gap(2, p);
    gap(2, p); chk("R3 fb0 period with half tick rate", p, 40);
    alt = 1'b0;

    // R6: park channel 1, channel 0 unaffected
    @(negedge clk); run = 2'b01;
    repeat (3) @(negedge clk);
    hits = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (cmp[1] || fb[1]) hits++;
    end
    chk("R6 parked channel pulses", hits, 0);
    gap(0, p); chk("R6 cmp0 period while ch1 parked", p, 10);

    // R7: channel 1 wakes onto the running shared reference
    repeat (4) @(negedge clk);
    run = 2'b11; tc = -1; tf = -1; k = 0; co = 0;
    while ((tc < 0 || tf < 0) && k < 1000) begin
      @(negedge clk);
      k++;
      if (cmp[1] && tc < 0) begin tc = k; co = int'(cmp[0]); end
      if (fb[1] && tf < 0) tf = k;
    end
    chk("R7 first cmp1 coincides with cmp0", co, 1);
    chk("R7 fb1 minus cmp1 first edge", tf - tc, 30 - 10);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule